// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection

This block takes an asynchronous serial line and turns it into received characters. Reception follows the usual 8-bit controller pattern. A frame starts with a low start bit. Data bits follow, least significant bit first. In the short format there are 8 data bits. In the long format there are 9 data bits, and the ninth is captured on its own. The frame ends with a stop bit that should be high.

The line is brought into the clock domain through a short synchronizer. It is then sampled on an external enable, `baud_tick`, which must pulse at 16 times the bit rate. A start edge is confirmed at mid-bit before a frame is accepted. Every later bit is decided by a 2-of-3 vote of the samples taken around its centre.

Results are reported through software-style pins:
- a sticky receive flag;
- a sticky framing-error status;
- a sticky break status;
- a one-cycle break interrupt request, which outside logic can use to react to a break.

Each sticky bit has its own clear strobe. There is no back-pressure. The receive flag is the only handshake: a character that arrives while the flag is still set overwrites the held data, and the flag stays set.

Top module: `serial_rx_engine`

## Requirements
- R1: In short format (`nine_bit`=0), the 8 data bits are assembled LSB first into `rx_data`. `rb8` takes the sampled stop bit. `rx_flag` rises at the centre of the stop bit.
- R2: In long format (`nine_bit`=1), `rb8` takes the ninth data bit. With `late_sel`=0, `rx_flag` rises at the centre of that ninth bit, before the stop bit begins.
- R3: In long format with `late_sel`=1, `rx_flag` stays low through the ninth bit and rises at the centre of the stop bit.
- R4: `rx_flag` stays set until a `clr_rx_flag` pulse clears it. Hardware never clears it, and a new character does not clear it.
- R5: A stop bit sampled as 0 sets `ferr`. `ferr` holds until a `clr_ferr` pulse.
- R6: When the line has been low for 11 consecutive bit times (start bit included), `brk_det` is set and held until `clr_brk`. In the same event `brk_irq` pulses high for exactly one clock. A low run of 10 bit times followed by a high bit is not a break.
- R7: Every detected break also sets `ferr`.
- R8: After a break, the receiver accepts no frame until the line has been seen high. Continued low time raises neither `rx_flag` nor a second break.
- R9: While `rx_en` is 0, no frame is received and `rx_flag` does not rise. Dropping `rx_en` in the middle of a frame abandons that frame.
- R10: A low pulse shorter than half a bit time is rejected as a false start and produces no character.
- R11: A disturbance that corrupts a single oversample near the bit centre does not change the received bit.
- R12: After reset, `rx_flag`, `ferr`, `brk_det`, `brk_irq`, `rb8` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock enable at 16x the bit rate |
| rxd | input | 1 | Serial line, asynchronous |
| rx_en | input | 1 | Receive enable |
| nine_bit | input | 1 | 1 selects the 9-data-bit format |
| late_sel | input | 1 | Long format: 1 raises the flag at the stop bit instead of the ninth bit |
| clr_rx_flag | input | 1 | Clear pulse for `rx_flag` |
| clr_ferr | input | 1 | Clear pulse for `ferr` |
| clr_brk | input | 1 | Clear pulse for `brk_det` |
| rx_data | output | 8 | Last received data byte |
| rb8 | output | 1 | Ninth data bit (long format) or stop bit (short format) |
| rx_flag | output | 1 | Sticky receive-complete flag |
| ferr | output | 1 | Sticky framing error |
| brk_det | output | 1 | Sticky break status |
| brk_irq | output | 1 | One-clock break interrupt request |

## Verification
A bit counter that has slipped makes `rx_flag` rise one bit time too early or too late. It also leaves `rx_data` shifted by one position. Both show at the first frame after the fault, within about 700 clocks at the bench's tick rate.

A low-run counter that is wrong moves break detection by a whole bit. This is caught by sending runs of 10 and 11 low bits. A lost post-break wait shows as a spurious flag during the extra low time.

A voting or start-check fault shows only when the line is glitched, so those cases are driven on purpose.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD,
    ST_BRKWAIT
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_vote.sv
module srx_vote #(
  parameter int CNT_W = 4,
  parameter int MID   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             line,
  input  logic [CNT_W-1:0] ph,
  output logic             at_mid,
  output logic             vote
);
  logic early_a, early_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_a <= 1'b1;
      early_b <= 1'b1;
    end else if (tick) begin
      if (ph == CNT_W'(MID - 2)) early_a <= line;
      if (ph == CNT_W'(MID - 1)) early_b <= line;
    end
  end

  assign at_mid = tick && (ph == CNT_W'(MID));
  assign vote   = (early_a & early_b) | (early_a & line) | (early_b & line);
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int BRK_BITS = 11,
  localparam int CNT_W   = $clog2(OVS),
  localparam int IDX_W   = $clog2(DATA_W + 2),
  localparam int RUN_W   = $clog2(BRK_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              late_sel,
  input  logic              at_mid,
  input  logic              vote,
  output logic [CNT_W-1:0]  ph,
  output logic              ev_load,
  output logic [DATA_W-1:0] ev_data,
  output logic              ev_bit9,
  output logic              ev_ferr,
  output logic              ev_brk
);
  localparam int LAST = OVS - 1;

  rx_state_e          st;
  logic [IDX_W-1:0]   bit_idx;
  logic [IDX_W-1:0]   last_idx;
  logic [DATA_W:0]    shreg;
  logic [DATA_W:0]    shnext;
  logic [RUN_W-1:0]   low_run;
  logic [RUN_W-1:0]   run_inc;
  logic [RUN_W-1:0]   run_n;
  logic [CNT_W-1:0]   ph_nx;
  logic               run_full;

  assign shnext   = {vote, shreg[DATA_W:1]};
  assign run_inc  = (low_run == RUN_W'(BRK_BITS)) ? low_run : low_run + 1'b1;
  assign run_n    = vote ? '0 : run_inc;
  assign run_full = (run_n >= RUN_W'(BRK_BITS));
  assign last_idx = nine_bit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign ph_nx    = (ph == CNT_W'(LAST)) ? '0 : ph + 1'b1;

  always_comb begin
    ev_load = 1'b0;
    ev_data = '0;
    ev_bit9 = 1'b0;
    ev_ferr = 1'b0;
    ev_brk  = 1'b0;
    if (rx_en && at_mid) begin
      case (st)
        ST_DATA: begin
          if (nine_bit && !late_sel && bit_idx == IDX_W'(DATA_W)) begin
            ev_load = 1'b1;
            ev_data = shnext[DATA_W-1:0];
            ev_bit9 = vote;
          end
        end
        ST_STOP: begin
          ev_ferr = !vote;
          ev_brk  = run_full;
          if (!nine_bit) begin
            ev_load = 1'b1;
            ev_data = shreg[DATA_W:1];
            ev_bit9 = vote;
          end else if (late_sel) begin
            ev_load = 1'b1;
            ev_data = shreg[DATA_W-1:0];
            ev_bit9 = shreg[DATA_W];
          end
        end
        ST_HOLD: ev_brk = run_full;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      low_run <= '0;
    end else if (!rx_en && st != ST_BRKWAIT) begin
      st <= ST_IDLE;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          if (!line) begin
            st      <= ST_START;
            ph      <= '0;
            low_run <= '0;
          end
        end
        ST_START: begin
          ph <= ph_nx;
          if (at_mid) begin
            if (vote) st <= ST_IDLE;
            else      low_run <= RUN_W'(1);
          end
          if (ph == CNT_W'(LAST)) begin
            st      <= ST_DATA;
            bit_idx <= '0;
          end
        end
        ST_DATA: begin
          ph <= ph_nx;
          if (at_mid) begin
            shreg   <= shnext;
            low_run <= run_n;
          end
          if (ph == CNT_W'(LAST)) begin
            if (bit_idx == last_idx) st <= ST_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_STOP, ST_HOLD: begin
          ph <= ph_nx;
          if (at_mid) begin
            low_run <= run_n;
            if (run_full)  st <= ST_BRKWAIT;
            else if (vote) st <= ST_IDLE;
            else           st <= ST_HOLD;
          end
        end
        ST_BRKWAIT: begin
          if (line) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              ev_bit9,
  input  logic              ev_ferr,
  input  logic              ev_brk,
  input  logic              clr_rx_flag,
  input  logic              clr_ferr,
  input  logic              clr_brk,
  output logic [DATA_W-1:0] rx_data,
  output logic              rb8,
  output logic              rx_flag,
  output logic              ferr,
  output logic              brk_det,
  output logic              brk_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rb8     <= 1'b0;
      rx_flag <= 1'b0;
      ferr    <= 1'b0;
      brk_det <= 1'b0;
      brk_irq <= 1'b0;
    end else begin
      if (ev_load) begin
        rx_data <= ev_data;
        rb8     <= ev_bit9;
      end
      if (ev_load)          rx_flag <= 1'b1;
      else if (clr_rx_flag) rx_flag <= 1'b0;
      if (ev_ferr || ev_brk) ferr <= 1'b1;
      else if (clr_ferr)     ferr <= 1'b0;
      if (ev_brk)       brk_det <= 1'b1;
      else if (clr_brk) brk_det <= 1'b0;
      brk_irq <= ev_brk;
    end
  end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int BRK_BITS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              late_sel,
  input  logic              clr_rx_flag,
  input  logic              clr_ferr,
  input  logic              clr_brk,
  output logic [DATA_W-1:0] rx_data,
  output logic              rb8,
  output logic              rx_flag,
  output logic              ferr,
  output logic              brk_det,
  output logic              brk_irq
);
  localparam int CNT_W = $clog2(OVS);
  localparam int MID   = OVS / 2;

  logic              line;
  logic              at_mid;
  logic              vote;
  logic [CNT_W-1:0]  ph;
  logic              ev_load;
  logic [DATA_W-1:0] ev_data;
  logic              ev_bit9;
  logic              ev_ferr;
  logic              ev_brk;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line)
  );

  srx_vote #(.CNT_W(CNT_W), .MID(MID)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(line), .ph(ph),
    .at_mid(at_mid), .vote(vote)
  );

  srx_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .BRK_BITS(BRK_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(line), .rx_en(rx_en),
    .nine_bit(nine_bit), .late_sel(late_sel), .at_mid(at_mid), .vote(vote),
    .ph(ph), .ev_load(ev_load), .ev_data(ev_data), .ev_bit9(ev_bit9),
    .ev_ferr(ev_ferr), .ev_brk(ev_brk)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_data(ev_data),
    .ev_bit9(ev_bit9), .ev_ferr(ev_ferr), .ev_brk(ev_brk),
    .clr_rx_flag(clr_rx_flag), .clr_ferr(clr_ferr), .clr_brk(clr_brk),
    .rx_data(rx_data), .rb8(rb8), .rx_flag(rx_flag), .ferr(ferr),
    .brk_det(brk_det), .brk_irq(brk_irq)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              baud_tick,
  input logic              rxd,
  input logic              rx_en,
  input logic              nine_bit,
  input logic              late_sel,
  input logic              clr_rx_flag,
  input logic              clr_ferr,
  input logic              clr_brk,
  input logic [DATA_W-1:0] rx_data,
  input logic              rb8,
  input logic              rx_flag,
  input logic              ferr,
  input logic              brk_det,
  input logic              brk_irq
);
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flag) |-> $past(clr_rx_flag));

  p_ferr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ferr) |-> $past(clr_ferr));

  p_brk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_det) |-> $past(clr_brk));

  p_irq_with_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> brk_det);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |=> !brk_irq);

  p_break_is_ferr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> ferr);

  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(rx_en));
endmodule

bind serial_rx_engine srx_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_serial_rx_engine.sv
module tb_serial_rx_engine;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic       late_sel = 1'b0;
  logic       clr_rx_flag = 1'b0;
  logic       clr_ferr = 1'b0;
  logic       clr_brk = 1'b0;
  logic [7:0] rx_data;
  logic       rb8, rx_flag, ferr, brk_det, brk_irq;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  int irq_wide = 0;
  bit done = 0;

  serial_rx_engine dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .rx_en(rx_en),
    .nine_bit(nine_bit), .late_sel(late_sel), .clr_rx_flag(clr_rx_flag),
    .clr_ferr(clr_ferr), .clr_brk(clr_brk), .rx_data(rx_data), .rb8(rb8),
    .rx_flag(rx_flag), .ferr(ferr), .brk_det(brk_det), .brk_irq(brk_irq)
  );

  always #2 clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      baud_tick = (tc % TICK_DIV == 0);
    end
  end

  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (brk_irq) irq_cnt++;
    if (brk_irq && irq_prev) irq_wide++;
    irq_prev = brk_irq;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold_bits(input logic v, input int n);
    rxd = v;
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  task automatic glitch_bit(input logic v);
    rxd = v;
    repeat (BIT_CLK / 2 - 2) @(negedge clk);
    rxd = ~v;
    repeat (TICK_DIV) @(negedge clk);
    rxd = v;
    repeat (BIT_CLK / 2 + 2 - TICK_DIV) @(negedge clk);
  endtask

  task automatic send_head(input logic [8:0] d, input int nbits);
    hold_bits(1'b0, 1);
    for (int i = 0; i < nbits; i++) hold_bits(d[i], 1);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic clear_all();
    pulse(clr_rx_flag);
    pulse(clr_ferr);
    pulse(clr_brk);
  endtask

  task automatic t_reset();
    check("R12 flag", rx_flag, 0);
    check("R12 ferr", ferr, 0);
    check("R12 brk", brk_det, 0);
    check("R12 irq", brk_irq, 0);
    check("R12 data", {rb8, rx_data}, 0);
  endtask

  task automatic t_short_frame();
    nine_bit = 0;
    send_head(9'h0A5, 8);
    check("R1 flag before stop", rx_flag, 0);
    hold_bits(1'b1, 1);
    check("R1 flag", rx_flag, 1);
    check("R1 data", rx_data, 8'hA5);
    check("R1 rb8=stop", rb8, 1);
    check("R5 no ferr", ferr, 0);
    hold_bits(1'b1, 3);
    check("R4 flag sticky", rx_flag, 1);
    send_head(9'h033, 8);
    hold_bits(1'b1, 1);
    check("R4 flag still set", rx_flag, 1);
    check("R4 data overwritten", rx_data, 8'h33);
    pulse(clr_rx_flag);
    check("R4 cleared", rx_flag, 0);
  endtask

  task automatic t_ferr();
    send_head(9'h03C, 8);
    hold_bits(1'b0, 1);
    hold_bits(1'b1, 1);
    check("R5 ferr", ferr, 1);
    check("R1 rb8 low stop", rb8, 0);
    check("R6 no brk", brk_det, 0);
    hold_bits(1'b1, 2);
    check("R5 ferr sticky", ferr, 1);
    pulse(clr_ferr);
    check("R5 ferr cleared", ferr, 0);
    pulse(clr_rx_flag);
  endtask

  task automatic t_nine_early();
    nine_bit = 1; late_sel = 0;
    send_head(9'h15A, 9);
    check("R2 flag at 9th bit", rx_flag, 1);
    check("R2 data", rx_data, 8'h5A);
    check("R2 rb8", rb8, 1);
    hold_bits(1'b1, 2);
    pulse(clr_rx_flag);
  endtask

  task automatic t_nine_late();
    nine_bit = 1; late_sel = 1;
    send_head(9'h0C3, 9);
    check("R3 flag low before stop", rx_flag, 0);
    hold_bits(1'b1, 1);
    check("R3 flag at stop", rx_flag, 1);
    check("R3 data", rx_data, 8'hC3);
    check("R3 rb8", rb8, 0);
    hold_bits(1'b1, 1);
    pulse(clr_rx_flag);
    late_sel = 0;
  endtask

  task automatic t_ten_low();
    nine_bit = 0;
    hold_bits(1'b0, 10);
    hold_bits(1'b1, 2);
    check("R6 ten lows not break", brk_det, 0);
    check("R5 ten lows ferr", ferr, 1);
    clear_all();
  endtask

  task automatic t_break_short();
    int irq0 = irq_cnt;
    nine_bit = 0;
    hold_bits(1'b0, 11);
    check("R6 brk short", brk_det, 1);
    check("R7 ferr on brk", ferr, 1);
    check("R6 irq once", irq_cnt - irq0, 1);
    clear_all();
    hold_bits(1'b0, 4);
    check("R8 no flag in wait", rx_flag, 0);
    check("R8 no second brk", brk_det, 0);
    hold_bits(1'b1, 1);
    send_head(9'h096, 8);
    hold_bits(1'b1, 1);
    check("R8 resume after high", rx_data, 8'h96);
    check("R8 flag after resume", rx_flag, 1);
    clear_all();
  endtask

  task automatic t_break_long();
    int irq0 = irq_cnt;
    nine_bit = 1;
    hold_bits(1'b0, 11);
    check("R6 brk long", brk_det, 1);
    check("R7 ferr long", ferr, 1);
    check("R6 irq long", irq_cnt - irq0, 1);
    hold_bits(1'b1, 1);
    clear_all();
    nine_bit = 0;
  endtask

  task automatic t_enable();
    rx_en = 0;
    send_head(9'h0F0, 8);
    hold_bits(1'b1, 2);
    check("R9 disabled no flag", rx_flag, 0);
    rx_en = 1;
    send_head(9'h0FF, 4);
    rx_en = 0;
    send_head(9'h0FF, 4);
    hold_bits(1'b1, 1);
    rx_en = 1;
    hold_bits(1'b1, 2);
    check("R9 abort mid frame", rx_flag, 0);
  endtask

  task automatic t_false_start();
    rxd = 0;
    repeat (3 * TICK_DIV) @(negedge clk);
    hold_bits(1'b1, 12);
    check("R10 false start", rx_flag, 0);
  endtask

  task automatic t_glitch();
    hold_bits(1'b0, 1);
    glitch_bit(1); glitch_bit(1); glitch_bit(1); glitch_bit(1);
    glitch_bit(0); glitch_bit(0); glitch_bit(0); glitch_bit(0);
    hold_bits(1'b1, 1);
    check("R11 glitch flag", rx_flag, 1);
    check("R11 glitch data", rx_data, 8'h0F);
    pulse(clr_rx_flag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    rx_en = 1;
    hold_bits(1'b1, 2);
    t_short_frame();
    t_ferr();
    t_nine_early();
    t_nine_late();
    t_ten_low();
    t_break_short();
    t_break_long();
    t_enable();
    t_false_start();
    t_glitch();
    check("R6 irq one clock", irq_wide, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule